// File: doc/BRIEF.md
# Dual-Layout 8-bit Floating-Point Adder/Subtractor

This block adds or subtracts two 8-bit floating-point operands and returns a correctly rounded 8-bit result in the same layout. A single select input picks the layout for both operands and the result. The first layout has a 4-bit exponent and a 3-bit fraction and has no infinity. The second layout has a 5-bit exponent and a 2-bit fraction and follows the usual infinity and NaN conventions. Subnormal inputs and outputs are supported. Rounding is always to nearest, with ties going to the even value.

The datapath has two register stages. The first stage unpacks both operands, orders them by magnitude, aligns the smaller one and forms the signed sum. It also resolves NaN and infinity cases. The second stage renormalises the sum, rounds it, detects overflow and packs the result word with three exception flags. A new operation can be accepted on every clock. Each accepted operation comes out exactly two clocks later, marked by `out_valid`.

Top module: `fp8_addsub`

## Requirements
- R1: With `fmt_sel`=0, words are {sign[7], exponent[6:3], fraction[2:0]} with bias 7. With `fmt_sel`=1, words are {sign[7], exponent[6:2], fraction[1:0]} with bias 15. `result` equals `op_a`+`op_b` when `op_sub`=0 and `op_a`-`op_b` when `op_sub`=1, rounded to the selected layout.
- R2: An exponent field of 0 denotes a subnormal value with no hidden leading one. This holds for inputs and for outputs.
- R3: Rounding is to nearest. An exact halfway case rounds to the candidate whose fraction LSB is 0.
- R4: With `fmt_sel`=0, a rounded magnitude above 448 sets `flag_ovf` and saturates `result` to sign.1111.110 (0x7E or 0xFE).
- R5: With `fmt_sel`=1, a rounded exponent of 31 or more sets `flag_ovf` and returns infinity, sign.11111.00 (0x7C or 0xFC).
- R6: NaN inputs are x.1111.111 when `fmt_sel`=0, and exponent 11111 with a nonzero fraction when `fmt_sel`=1. Any NaN input yields 0x7F with `flag_inv` set. With `fmt_sel`=0 the code 0x7F/0xFF is never produced without `flag_inv`.
- R7: With `fmt_sel`=1, infinity plus a finite value or a like-signed infinity gives that infinity with no flag. Infinities of opposite effective sign give 0x7F with `flag_inv` set.
- R8: An exact zero sum of nonzero values gives +0 (0x00). The sum of two zeros is -0 only when both effective signs are negative.
- R9: `flag_unf` is set when the result is nonzero and has exponent field 0. At most one of the three flags is set for any result.
- R10: Each operation presented with `in_valid`=1 produces `out_valid`=1 exactly two rising edges later. Without `in_valid`, no output appears. Back-to-back operations are accepted every cycle.
- R11: While `rst_n` is low, `out_valid`, `result` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op_a | input | 8 | First operand |
| op_b | input | 8 | Second operand |
| op_sub | input | 1 | 1 subtracts op_b, 0 adds it |
| fmt_sel | input | 1 | Layout select: 0 = 4-bit exponent, 1 = 5-bit exponent |
| out_valid | output | 1 | Result and flags are valid |
| result | output | 8 | Rounded sum or difference |
| flag_ovf | output | 1 | Result overflowed (saturated or infinity) |
| flag_unf | output | 1 | Result is a nonzero subnormal |
| flag_inv | output | 1 | Invalid operation; result is NaN |

## Verification
Every result and its three flags are due on the second rising edge after the operation is accepted. The bench stamps each expected item with that cycle number when it pushes the item. The monitor samples on the falling edge that follows the second rising edge and pops an item only when `out_valid` is high. It reports an output that arrives early, late or unrequested, as well as an expected output that never appears. Idle gaps between directed operations confirm that no output appears without a matching input, and the exhaustive sweep keeps the pipeline full every cycle.

// File: rtl/fp8_add_pkg.sv
package fp8_add_pkg;

    localparam int FP8_W  = 8;
    localparam int SIG_W  = 4;
    localparam int GRD_W  = 3;
    localparam int EXT_W  = SIG_W + GRD_W;
    localparam int SUM_W  = EXT_W + 1;
    localparam int EXP_W  = 5;
    localparam int EXPI_W = EXP_W + 1;
    localparam int SHC_W  = $clog2(EXT_W + 1);

    localparam logic [FP8_W-1:0] NAN_WORD = 8'h7F;
    localparam logic [FP8_W-2:0] SAT_MAG  = 7'h7E;
    localparam logic [FP8_W-2:0] INF_MAG  = 7'h7C;

    typedef enum logic {
        FMT_A43 = 1'b0,
        FMT_B52 = 1'b1
    } fp8_fmt_e;

    typedef struct packed {
        logic             sign;
        logic [EXP_W-1:0] exp;
        logic [SIG_W-1:0] sig;
        logic             is_nan;
        logic             is_inf;
    } fp8_unp_t;

endpackage

// File: rtl/fp8_unpack.sv
module fp8_unpack
    import fp8_add_pkg::*;
(
    input  logic [FP8_W-1:0] word,
    input  fp8_fmt_e         fmt,
    output fp8_unp_t         unp
);

    logic [3:0] exp_a43;
    logic [4:0] exp_b52;

    assign exp_a43 = word[6:3];
    assign exp_b52 = word[6:2];

    always_comb begin
        unp      = '0;
        unp.sign = word[FP8_W-1];
        unique case (fmt)
            FMT_A43: begin
                unp.exp    = (exp_a43 == '0) ? EXP_W'(1) : EXP_W'(exp_a43);
                unp.sig    = {|exp_a43, word[2:0]};
                unp.is_nan = &word[6:0];
            end
            FMT_B52: begin
                unp.exp    = (exp_b52 == '0) ? EXP_W'(1) : exp_b52;
                unp.sig    = {|exp_b52, word[1:0], 1'b0};
                unp.is_nan = (&exp_b52) & (|word[1:0]);
                unp.is_inf = (&exp_b52) & ~(|word[1:0]);
            end
        endcase
    end

endmodule

// File: rtl/fp8_align_add.sv
module fp8_align_add
    import fp8_add_pkg::*;
(
    input  fp8_unp_t          opa,
    input  fp8_unp_t          opb,
    input  logic              sub,
    output logic              spec_hit,
    output logic [FP8_W-1:0]  spec_word,
    output logic              spec_inv,
    output logic              res_sign,
    output logic [EXPI_W-1:0] res_exp,
    output logic [SUM_W-1:0]  res_sum
);

    logic             sign_b;
    logic             a_big;
    logic             big_sign, sml_sign;
    logic [EXP_W-1:0] big_exp,  sml_exp, exp_diff;
    logic [SIG_W-1:0] big_sig,  sml_sig;
    logic [SHC_W-1:0] shamt;
    logic [EXT_W-1:0] big_ext, sml_ext, sml_shift, lost_mask, aligned;
    logic             sticky, eff_sub;
    logic             any_nan, inf_clash;

    assign sign_b = opb.sign ^ sub;
    assign a_big  = {opa.exp, opa.sig} >= {opb.exp, opb.sig};

    // magnitude ordering: larger operand on the "big" side
    always_comb begin
        if (a_big) begin
            big_sign = opa.sign; big_exp = opa.exp; big_sig = opa.sig;
            sml_sign = sign_b;   sml_exp = opb.exp; sml_sig = opb.sig;
        end else begin
            big_sign = sign_b;   big_exp = opb.exp; big_sig = opb.sig;
            sml_sign = opa.sign; sml_exp = opa.exp; sml_sig = opa.sig;
        end
    end

    // alignment with guard bits and a folded sticky bit
    assign exp_diff  = big_exp - sml_exp;
    assign shamt     = (exp_diff > EXP_W'(EXT_W)) ? SHC_W'(EXT_W) : SHC_W'(exp_diff);
    assign big_ext   = {big_sig, {GRD_W{1'b0}}};
    assign sml_ext   = {sml_sig, {GRD_W{1'b0}}};
    assign sml_shift = sml_ext >> shamt;
    assign lost_mask = (EXT_W'(1) << shamt) - EXT_W'(1);
    assign sticky    = |(sml_ext & lost_mask);
    assign aligned   = sml_shift | {{(EXT_W-1){1'b0}}, sticky};
    assign eff_sub   = big_sign ^ sml_sign;

    always_comb begin
        if (eff_sub) res_sum = {1'b0, big_ext} - {1'b0, aligned};
        else         res_sum = {1'b0, big_ext} + {1'b0, aligned};
    end

    assign res_sign = (res_sum == '0) ? (opa.sign & sign_b) : big_sign;
    assign res_exp  = {1'b0, big_exp};

    // special operands
    assign any_nan   = opa.is_nan | opb.is_nan;
    assign inf_clash = opa.is_inf & opb.is_inf & (opa.sign ^ sign_b);
    assign spec_inv  = any_nan | inf_clash;
    assign spec_hit  = any_nan | opa.is_inf | opb.is_inf;

    always_comb begin
        if (spec_inv)       spec_word = NAN_WORD;
        else if (opa.is_inf) spec_word = {opa.sign, INF_MAG};
        else                 spec_word = {sign_b, INF_MAG};
    end

endmodule

// File: rtl/fp8_norm_round.sv
module fp8_norm_round
    import fp8_add_pkg::*;
(
    input  fp8_fmt_e          fmt,
    input  logic              sign_in,
    input  logic [EXPI_W-1:0] exp_in,
    input  logic [SUM_W-1:0]  sum_in,
    output logic [FP8_W-1:0]  word,
    output logic              ovf,
    output logic              unf
);

    logic [SHC_W-1:0]  lz;
    logic [EXPI_W-1:0] lim, sh, ne, e_out, expf;
    logic [EXT_W-1:0]  nrm;
    logic              g_bit, st_bit, inc, carry, hid;
    logic [4:0]        rnd_a;
    logic [3:0]        rnd_b;
    logic [2:0]        man;

    // leading-zero count over the in-range bits
    always_comb begin
        lz = SHC_W'(EXT_W);
        for (int i = 0; i < EXT_W; i++) begin
            if (sum_in[i]) lz = SHC_W'(EXT_W - 1 - i);
        end
    end

    // renormalise: right by one on carry-out, else left, floored at exponent 1
    always_comb begin
        lim = exp_in - EXPI_W'(1);
        sh  = '0;
        if (sum_in[SUM_W-1]) begin
            nrm = {sum_in[SUM_W-1:2], sum_in[1] | sum_in[0]};
            ne  = exp_in + EXPI_W'(1);
        end else begin
            sh  = (EXPI_W'(lz) > lim) ? lim : EXPI_W'(lz);
            nrm = sum_in[EXT_W-1:0] << sh;
            ne  = exp_in - sh;
        end
    end

    // round to nearest even, then pack
    always_comb begin
        word   = '0;
        ovf    = 1'b0;
        unf    = 1'b0;
        rnd_a  = '0;
        rnd_b  = '0;
        g_bit  = 1'b0;
        st_bit = 1'b0;
        inc    = 1'b0;
        carry  = 1'b0;
        hid    = 1'b0;
        man    = '0;
        e_out  = ne;
        expf   = '0;
        unique case (fmt)
            FMT_A43: begin
                g_bit  = nrm[2];
                st_bit = |nrm[1:0];
                inc    = g_bit & (st_bit | nrm[3]);
                rnd_a  = {1'b0, nrm[6:3]} + 5'(inc);
                carry  = rnd_a[4];
                hid    = rnd_a[4] | rnd_a[3];
                man    = carry ? 3'b000 : rnd_a[2:0];
                e_out  = ne + EXPI_W'(carry);
                expf   = hid ? e_out : '0;
                if (e_out > EXPI_W'(15) || (e_out == EXPI_W'(15) && man == 3'b111)) begin
                    word = {sign_in, SAT_MAG};
                    ovf  = 1'b1;
                end else begin
                    word = {sign_in, expf[3:0], man};
                    unf  = (expf == '0) && (man != '0);
                end
            end
            FMT_B52: begin
                g_bit  = nrm[3];
                st_bit = |nrm[2:0];
                inc    = g_bit & (st_bit | nrm[4]);
                rnd_b  = {1'b0, nrm[6:4]} + 4'(inc);
                carry  = rnd_b[3];
                hid    = rnd_b[3] | rnd_b[2];
                man    = carry ? 3'b000 : {1'b0, rnd_b[1:0]};
                e_out  = ne + EXPI_W'(carry);
                expf   = hid ? e_out : '0;
                if (e_out >= EXPI_W'(31)) begin
                    word = {sign_in, INF_MAG};
                    ovf  = 1'b1;
                end else begin
                    word = {sign_in, expf[4:0], man[1:0]};
                    unf  = (expf == '0) && (man != '0);
                end
            end
        endcase
    end

endmodule

// File: rtl/fp8_addsub.sv
module fp8_addsub
    import fp8_add_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [FP8_W-1:0] op_a,
    input  logic [FP8_W-1:0] op_b,
    input  logic             op_sub,
    input  logic             fmt_sel,
    output logic             out_valid,
    output logic [FP8_W-1:0] result,
    output logic             flag_ovf,
    output logic             flag_unf,
    output logic             flag_inv
);

    localparam int N_OPS = 2;

    fp8_fmt_e                     fmt_in;
    logic [N_OPS-1:0][FP8_W-1:0]  op_words;
    fp8_unp_t                     unp [N_OPS];

    logic              c_spec_hit, c_spec_inv, c_sign;
    logic [FP8_W-1:0]  c_spec_word;
    logic [EXPI_W-1:0] c_exp;
    logic [SUM_W-1:0]  c_sum;

    // stage-1 registers
    logic              s1_valid, s1_spec_hit, s1_spec_inv, s1_sign;
    fp8_fmt_e          s1_fmt;
    logic [FP8_W-1:0]  s1_spec_word;
    logic [EXPI_W-1:0] s1_exp;
    logic [SUM_W-1:0]  s1_sum;

    logic [FP8_W-1:0]  n_word;
    logic              n_ovf, n_unf;

    assign fmt_in      = fp8_fmt_e'(fmt_sel);
    assign op_words[0] = op_a;
    assign op_words[1] = op_b;

    for (genvar gi = 0; gi < N_OPS; gi++) begin : g_unpack
        fp8_unpack i_unpack (
            .word (op_words[gi]),
            .fmt  (fmt_in),
            .unp  (unp[gi])
        );
    end

    fp8_align_add i_align (
        .opa       (unp[0]),
        .opb       (unp[1]),
        .sub       (op_sub),
        .spec_hit  (c_spec_hit),
        .spec_word (c_spec_word),
        .spec_inv  (c_spec_inv),
        .res_sign  (c_sign),
        .res_exp   (c_exp),
        .res_sum   (c_sum)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid     <= 1'b0;
            s1_fmt       <= FMT_A43;
            s1_spec_hit  <= 1'b0;
            s1_spec_inv  <= 1'b0;
            s1_spec_word <= '0;
            s1_sign      <= 1'b0;
            s1_exp       <= '0;
            s1_sum       <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_fmt       <= fmt_in;
                s1_spec_hit  <= c_spec_hit;
                s1_spec_inv  <= c_spec_inv;
                s1_spec_word <= c_spec_word;
                s1_sign      <= c_sign;
                s1_exp       <= c_exp;
                s1_sum       <= c_sum;
            end
        end
    end

    fp8_norm_round i_round (
        .fmt     (s1_fmt),
        .sign_in (s1_sign),
        .exp_in  (s1_exp),
        .sum_in  (s1_sum),
        .word    (n_word),
        .ovf     (n_ovf),
        .unf     (n_unf)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            flag_ovf  <= 1'b0;
            flag_unf  <= 1'b0;
            flag_inv  <= 1'b0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                if (s1_spec_hit) begin
                    result   <= s1_spec_word;
                    flag_ovf <= 1'b0;
                    flag_unf <= 1'b0;
                    flag_inv <= s1_spec_inv;
                end else begin
                    result   <= n_word;
                    flag_ovf <= n_ovf;
                    flag_unf <= n_unf;
                    flag_inv <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/fp8_addsub_chk.sv
module fp8_addsub_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       fmt_sel,
    input logic       out_valid,
    input logic [7:0] result,
    input logic       flag_ovf,
    input logic       flag_unf,
    input logic       flag_inv
);

    assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);

    assert_no_spurious_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid);

    assert_one_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $onehot0({flag_ovf, flag_unf, flag_inv}));

    assert_nan_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flag_inv) |-> (result == 8'h7F));

    assert_saturate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !fmt_sel) |-> ##2 (!flag_ovf || result[6:0] == 7'h7E));

    assert_infinity_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fmt_sel) |-> ##2 (!flag_ovf || result[6:0] == 7'h7C));

    assert_unf_subnormal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !fmt_sel) |-> ##2 (!flag_unf || result[6:3] == 4'd0));

    assert_no_nan_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !fmt_sel) |-> ##2 (flag_inv || result[6:0] != 7'h7F));

endmodule

bind fp8_addsub fp8_addsub_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .fmt_sel   (fmt_sel),
    .out_valid (out_valid),
    .result    (result),
    .flag_ovf  (flag_ovf),
    .flag_unf  (flag_unf),
    .flag_inv  (flag_inv)
);

// File: tb/test_fp8_addsub.sv
`timescale 1ns/1ps
module test_fp8_addsub;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid;
    logic [7:0] op_a, op_b;
    logic       op_sub, fmt_sel;
    logic       out_valid;
    logic [7:0] result;
    logic       flag_ovf, flag_unf, flag_inv;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [7:0] res;
        logic       ovf, unf, inv;
        int         tag;
        int         due;
        logic [7:0] a, b;
        logic       sub, fmt;
    } exp_t;

    exp_t sb_q[$];

    always #2 clk = ~clk;   // 250 MHz

    always @(posedge clk) cyc <= cyc + 1;

    fp8_addsub i_fp8_addsub (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op_a      (op_a),
        .op_b      (op_b),
        .op_sub    (op_sub),
        .fmt_sel   (fmt_sel),
        .out_valid (out_valid),
        .result    (result),
        .flag_ovf  (flag_ovf),
        .flag_unf  (flag_unf),
        .flag_inv  (flag_inv)
    );

    function automatic string tag_name(int t);
        case (t)
            1:  return "R1";
            2:  return "R2";
            3:  return "R3";
            4:  return "R4";
            5:  return "R5";
            6:  return "R6";
            7:  return "R7";
            8:  return "R8";
            9:  return "R9";
            10: return "R10";
            default: return "R11";
        endcase
    endfunction

    // exact magnitude in units of 2^-16
    function automatic longint mag_of(logic fmt, logic [7:0] x);
        int e, m;
        if (!fmt) begin
            e = int'(x[6:3]); m = int'(x[2:0]);
            if (e == 0) return longint'(m) << 7;
            return longint'(8 + m) << (e + 6);
        end
        e = int'(x[6:2]); m = int'(x[1:0]);
        if (e == 0) return longint'(m);
        return longint'(4 + m) << (e - 1);
    endfunction

    // reference: exact sum then a single nearest-even rounding (R1, R3)
    function automatic void ref_op(input logic fmt, input logic [7:0] a, input logic [7:0] b,
                                   input logic sub, output logic [7:0] r, output logic ovf,
                                   output logic unf, output logic inv, output int tag);
        logic   sa, sb, nan_a, nan_b, inf_a, inf_b, sgn, tie;
        longint s, mag, ulp, q, rm, half;
        int     e, mb, bias, lim;
        logic [7:0] expf, man;
        sa = a[7]; sb = b[7] ^ sub;
        ovf = 1'b0; unf = 1'b0; inv = 1'b0; tag = 1;
        if (!fmt) begin
            nan_a = (a[6:0] == 7'h7F); nan_b = (b[6:0] == 7'h7F);
            inf_a = 1'b0; inf_b = 1'b0;
        end else begin
            nan_a = (a[6:2] == 5'h1F) && (a[1:0] != 0); nan_b = (b[6:2] == 5'h1F) && (b[1:0] != 0);
            inf_a = (a[6:0] == 7'h7C); inf_b = (b[6:0] == 7'h7C);
        end
        if (nan_a || nan_b) begin
            r = 8'h7F; inv = 1'b1; tag = 6; return;       // R6
        end
        if (inf_a || inf_b) begin                         // R7
            tag = 7;
            if (inf_a && inf_b && (sa != sb)) begin r = 8'h7F; inv = 1'b1; end
            else r = {inf_a ? sa : sb, 7'h7C};
            return;
        end
        s = (sa ? -mag_of(fmt, a) : mag_of(fmt, a)) + (sb ? -mag_of(fmt, b) : mag_of(fmt, b));
        if (s == 0) begin                                 // R8
            r = {sa & sb, 7'h00}; tag = 8; return;
        end
        sgn = (s < 0); mag = sgn ? -s : s;
        mb = fmt ? 2 : 3; bias = fmt ? 15 : 7; lim = fmt ? 31 : 16;
        e = 1;
        for (int k = 2; k <= lim; k++) if (mag >= (longint'(1) << (k - bias + 16))) e = k;
        ulp = longint'(1) << (e - bias - mb + 16);
        q = mag / ulp; rm = mag % ulp; half = ulp / 2;
        tie = (rm != 0) && (rm == half);
        if ((rm != 0) && (rm > half || (tie && q[0]))) q = q + 1;
        if (q == (longint'(1) << (mb + 1))) begin q = q >> 1; e = e + 1; end
        expf = (q >= (longint'(1) << mb)) ? 8'(e) : 8'd0;
        man  = 8'(q & ((longint'(1) << mb) - 1));
        if ((!fmt && (e > 15 || (e == 15 && man == 7))) || (fmt && e > 30)) begin
            ovf = 1'b1;
            r = {sgn, fmt ? 7'h7C : 7'h7E};
            tag = fmt ? 5 : 4;                            // R5 / R4
            return;
        end
        r = fmt ? {sgn, expf[4:0], man[1:0]} : {sgn, expf[3:0], man[2:0]};
        if (expf == 0 && man != 0) begin unf = 1'b1; tag = 2; end  // R2, R9
        else if (tie) tag = 3;                            // R3
    endfunction

    task automatic send(input logic fmt, input logic [7:0] a, input logic [7:0] b, input logic sub);
        exp_t it;
        @(negedge clk);
        in_valid = 1'b1; fmt_sel = fmt; op_a = a; op_b = b; op_sub = sub;
        ref_op(fmt, a, b, sub, it.res, it.ovf, it.unf, it.inv, it.tag);
        it.due = cyc + 2;
        it.a = a; it.b = b; it.sub = sub; it.fmt = fmt;
        sb_q.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // monitor: pops and compares as results appear
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid) begin
                if (sb_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R10 unexpected output: out_valid=1 expected 0 at cycle %0d", cyc);
                end else begin
                    exp_t h;
                    h = sb_q.pop_front();
                    checks++;
                    if (cyc != h.due) begin       // R10 latency
                        errors++;
                        $display("FAIL R10 latency: output at cycle %0d expected %0d", cyc, h.due);
                    end
                    checks++;
                    if ({result, flag_ovf, flag_unf, flag_inv} != {h.res, h.ovf, h.unf, h.inv}) begin
                        errors++;
                        $display("FAIL %s fmt=%0d a=%02h b=%02h sub=%0d: got %02h o%0d u%0d i%0d expected %02h o%0d u%0d i%0d",
                                 tag_name(h.tag), h.fmt, h.a, h.b, h.sub, result, flag_ovf, flag_unf, flag_inv,
                                 h.res, h.ovf, h.unf, h.inv);
                    end
                    checks++;
                    if ((int'(flag_ovf) + int'(flag_unf) + int'(flag_inv)) > 1) begin   // R9
                        errors++;
                        $display("FAIL R9 flags: got %0d%0d%0d expected at most one set", flag_ovf, flag_unf, flag_inv);
                    end
                end
            end else if (sb_q.size() > 0 && sb_q[0].due == cyc) begin
                checks++; errors++;
                $display("FAIL R10 missing output: out_valid=0 expected 1 at cycle %0d", cyc);
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL R10 watchdog: %0d cycles expected fewer", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; op_a = '0; op_b = '0; op_sub = 1'b0; fmt_sel = 1'b0;
        repeat (3) @(negedge clk);
        checks++;                                          // R11 reset state
        if ({out_valid, result, flag_ovf, flag_unf, flag_inv} != '0) begin
            errors++;
            $display("FAIL R11 reset: got v%0d %02h %0d%0d%0d expected all zero",
                     out_valid, result, flag_ovf, flag_unf, flag_inv);
        end
        rst_n = 1'b1;
        idle(2);

        // directed cases, with gaps so idle cycles are observed (R10)
        send(1'b0, 8'h38, 8'h38, 1'b0);   // R1 1+1
        send(1'b1, 8'h3C, 8'h3C, 1'b0);   // R1 other layout
        idle(3);
        send(1'b0, 8'h38, 8'h18, 1'b0);   // R3 tie to even, stays down
        send(1'b0, 8'h39, 8'h18, 1'b0);   // R3 tie to even, goes up
        send(1'b0, 8'h38, 8'h38, 1'b1);   // R8 exact cancellation
        send(1'b0, 8'h80, 8'h80, 1'b0);   // R8 -0 + -0
        idle(2);
        send(1'b0, 8'h7E, 8'h7E, 1'b0);   // R4 saturation
        send(1'b0, 8'hFE, 8'h7E, 1'b1);   // R4 negative saturation
        send(1'b1, 8'h7B, 8'h7B, 1'b0);   // R5 overflow to infinity
        send(1'b0, 8'h7F, 8'h01, 1'b0);   // R6 NaN input
        send(1'b1, 8'h7D, 8'h3C, 1'b0);   // R6 NaN input, other layout
        send(1'b1, 8'h7C, 8'h7C, 1'b1);   // R7 inf - inf
        send(1'b1, 8'hFC, 8'h3C, 1'b0);   // R7 -inf + finite
        send(1'b0, 8'h01, 8'h01, 1'b0);   // R2 subnormal sum, R9 flag
        send(1'b1, 8'h04, 8'h83, 1'b0);   // R2 normal minus subnormal
        idle(4);

        // exhaustive sweep of both layouts, back to back (R1)
        for (int f = 0; f < 2; f++)
            for (int a = 0; a < 256; a++)
                for (int b = 0; b < 256; b++)
                    send(1'(f), 8'(a), 8'(b), 1'(a ^ (b >> 3)));
        idle(6);

        if (!done) begin
            done = 1'b1;
            if (sb_q.size() != 0) begin
                checks++; errors++;
                $display("FAIL R10 pending: %0d items expected 0", sb_q.size());
            end
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule